// File: doc/BRIEF.md
# Compare-Output Waveform Timer

An 8-bit up-counter with two compare channels, A and B, each shaping the level of one output pin. Software loads a mode register, a waveform-extension register and two compare registers through a small write port; the counter advances one step on every clock where the count-enable input is high. Each channel turns the counter and its compare value into a pin level. It also produces an override flag that says whether the compare logic, and not the port latch, owns the pin.

Three counting schemes are supported: free-running (normal), clear-on-channel-A-compare (CTC) and fast PWM. In fast PWM the counter rises from 0 to TOP and wraps, and the pin is set or cleared at the wrap. The meaning of each channel's two-bit output field depends on whether the mode is a PWM mode and on the waveform-extension bit. The block also combines the pin level with the port data and direction bits to form the final pad value and its drive enable.

Top module: `tmr_wavegen`

## Requirements
- R1: Register map (addr): 0 = mode register {A field[7:6], B field[5:4], bits 3:2 always read 0, waveform-low[1:0]}; 1 = extension register, bit 3 is the waveform-extension bit and the other bits read 0; 2 = compare A; 3 = compare B; 4 = counter (read only); other addresses read 0. Every register resets to 0, and reads return the written (buffered) compare values.
- R2: Waveform-low 00 (normal) or 01 acts as non-PWM free counting with TOP 0xFF, and 10 acts as non-PWM CTC. In these modes the output field works as follows: 00 makes no change, 01 toggles the level on a match, 10 clears it on a match and 11 sets it on a match.
- R3: Waveform-low 11 is fast PWM. There, field 00 makes no change, and field 01 makes no change when the extension bit is 0 and toggles on a match when it is 1.
- R4: In fast PWM, field 10 clears the level on a match and sets it at the wrap to 0. Field 11 sets it on a match and clears it at the wrap.
- R5: In fast PWM with field 10 or 11, a match is ignored when the compare value equals TOP, and only the action at the wrap takes effect.
- R6: The override flag is 1 when the field is nonzero, except for field 01 in fast PWM with the extension bit 0, where it is 0.
- R7: The pad drive enable equals the direction bit. The pad value is the channel level when the override flag is 1 and the port bit otherwise.
- R8: TOP is 0xFF in normal mode and in fast PWM with the extension bit 0. TOP is the active compare A value in CTC and in fast PWM with the extension bit 1.
- R9: A match is the counter equal to the active compare value. The counter and the levels change only on enabled clocks: the level changes on the edge at which the counter leaves the matching value, and the counter goes to 0 after TOP and increments otherwise.
- R10: In fast PWM a compare write goes only to the buffer, and the active values load from the buffers on the wrap to 0. In non-PWM modes a write loads the active value at once.
- R11: In CTC the counter returns to 0 on the enabled clock after it equals compare A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| port_a | input | 1 | Port latch bit of pin A |
| ddr_a | input | 1 | Direction bit of pin A (1 = output) |
| port_b | input | 1 | Port latch bit of pin B |
| ddr_b | input | 1 | Direction bit of pin B (1 = output) |
| oc_a | output | 1 | Channel A level |
| oc_b | output | 1 | Channel B level |
| ovr_a | output | 1 | Channel A owns pin A |
| ovr_b | output | 1 | Channel B owns pin B |
| pad_a | output | 1 | Pad A value |
| pad_a_en | output | 1 | Pad A drive enable |
| pad_b | output | 1 | Pad B value |
| pad_b_en | output | 1 | Pad B drive enable |

## Verification
The block has no parameters, so the bench builds its single 8-bit configuration. It sweeps every waveform setting against every output-field code on both channels. The compare pairs used are below TOP, equal to each other, and equal to 0xFF, and the runs are long enough to cover a full 256-count period with gaps in the count enable. This reaches the match-equals-TOP case, the buffered reload at the wrap, and both pad sources under all direction settings.

// File: rtl/tmr_wavegen.sv
module tmr_wavegen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       port_a,
  input  logic       ddr_a,
  input  logic       port_b,
  input  logic       ddr_b,
  output logic       oc_a,
  output logic       oc_b,
  output logic       ovr_a,
  output logic       ovr_b,
  output logic       pad_a,
  output logic       pad_a_en,
  output logic       pad_b,
  output logic       pad_b_en
);
  logic [1:0] com_a, com_b, wgl;
  logic       wg2;
  logic [7:0] buf_a, buf_b, act_a, act_b, cnt, top;
  logic       pwm, ctc, wrap, match_a, match_b;

  assign pwm     = (wgl == 2'b11);
  assign ctc     = (wgl == 2'b10);
  assign top     = (ctc || (pwm && wg2)) ? act_a : 8'hFF;
  assign wrap    = (cnt == top);
  assign match_a = (cnt == act_a);
  assign match_b = (cnt == act_b);

  function automatic logic next_oc(input logic cur, input logic [1:0] com,
                                   input logic m, input logic ign, input logic w);
    logic r;
    r = cur;
    if (!pwm) begin
      case (com)
        2'b01:   if (m) r = ~cur;
        2'b10:   if (m) r = 1'b0;
        2'b11:   if (m) r = 1'b1;
        default: r = cur;
      endcase
    end else begin
      case (com)
        2'b01:   if (wg2 && m) r = ~cur;
        2'b10:   if (w) r = 1'b1; else if (m && !ign) r = 1'b0;
        2'b11:   if (w) r = 1'b0; else if (m && !ign) r = 1'b1;
        default: r = cur;
      endcase
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      com_a <= '0; com_b <= '0; wgl <= '0; wg2 <= 1'b0;
      buf_a <= '0; buf_b <= '0; act_a <= '0; act_b <= '0;
      cnt <= '0; oc_a <= 1'b0; oc_b <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          3'd0: begin com_a <= wr_data[7:6]; com_b <= wr_data[5:4]; wgl <= wr_data[1:0]; end
          3'd1: wg2 <= wr_data[3];
          3'd2: begin buf_a <= wr_data; if (!pwm) act_a <= wr_data; end
          3'd3: begin buf_b <= wr_data; if (!pwm) act_b <= wr_data; end
          default: ;
        endcase
      end
      if (tick) begin
        cnt  <= wrap ? 8'h00 : cnt + 8'h01;
        oc_a <= next_oc(oc_a, com_a, match_a, act_a == top, wrap);
        oc_b <= next_oc(oc_b, com_b, match_b, act_b == top, wrap);
        if (pwm && wrap) begin
          act_a <= buf_a;
          act_b <= buf_b;
        end
      end
    end
  end

  assign ovr_a    = (com_a != 2'b00) && !(pwm && com_a == 2'b01 && !wg2);
  assign ovr_b    = (com_b != 2'b00) && !(pwm && com_b == 2'b01 && !wg2);
  assign pad_a_en = ddr_a;
  assign pad_b_en = ddr_b;
  assign pad_a    = ovr_a ? oc_a : port_a;
  assign pad_b    = ovr_b ? oc_b : port_b;

  always_comb begin
    case (addr)
      3'd0:    rd_data = {com_a, com_b, 2'b00, wgl};
      3'd1:    rd_data = {4'b0000, wg2, 3'b000};
      3'd2:    rd_data = buf_a;
      3'd3:    rd_data = buf_b;
      3'd4:    rd_data = cnt;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

module tmr_wavegen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] rd_data,
  input logic       ddr_a,
  input logic       pad_a_en,
  input logic [7:0] cnt,
  input logic [7:0] act_b,
  input logic       pwm,
  input logic       ctc,
  input logic       wrap,
  input logic       match_a,
  input logic [1:0] com_a,
  input logic       oc_a
);
  assert_ctrl_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 3'd0 |-> rd_data[3:2] == 2'b00);
  assert_bottom_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && pwm && wrap && com_a == 2'b10 |=> oc_a);
  assert_pad_undriven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_a |-> !pad_a_en);
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  assert_buffer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwm && !(tick && wrap) |=> $stable(act_b));
  assert_ctc_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ctc && match_a && !wr_en |=> cnt == 8'h00);
endmodule

bind tmr_wavegen tmr_wavegen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .rd_data(rd_data), .ddr_a(ddr_a), .pad_a_en(pad_a_en), .cnt(cnt),
  .act_b(act_b), .pwm(pwm), .ctc(ctc), .wrap(wrap), .match_a(match_a),
  .com_a(com_a), .oc_a(oc_a)
);

// File: tb/test_tmr_wavegen.sv
module test_tmr_wavegen;
  localparam int PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic port_a = 1'b0, ddr_a = 1'b0, port_b = 1'b0, ddr_b = 1'b0;
  logic oc_a, oc_b, ovr_a, ovr_b, pad_a, pad_a_en, pad_b, pad_b_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [1:0] m_ca = 0, m_cb = 0, m_wl = 0;
  logic       m_w2 = 0, m_oa = 0, m_ob = 0;
  logic [7:0] m_ba = 0, m_bb = 0, m_aa = 0, m_ab = 0, m_cnt = 0;

  tmr_wavegen i_tmr_wavegen (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic m_pwm(); return m_wl == 2'b11; endfunction
  function automatic logic [7:0] m_top();
    return (m_wl == 2'b10 || (m_pwm() && m_w2)) ? m_aa : 8'hFF;
  endfunction
  function automatic logic m_ovr(input logic [1:0] c);
    return c != 0 && !(m_pwm() && c == 2'b01 && !m_w2);
  endfunction
  function automatic logic [7:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0: return {m_ca, m_cb, 2'b00, m_wl};
      3'd1: return {4'b0, m_w2, 3'b0};
      3'd2: return m_ba;
      3'd3: return m_bb;
      3'd4: return m_cnt;
      default: return 8'h00;
    endcase
  endfunction
  function automatic logic m_next(input logic cur, input logic [1:0] c,
                                  input logic [7:0] cmp);
    logic m, w, ign;
    m = (m_cnt == cmp); w = (m_cnt == m_top()); ign = (cmp == m_top());
    if (!m_pwm()) begin
      if (m && c == 2'b01) return ~cur;   // R2
      if (m && c == 2'b10) return 1'b0;
      if (m && c == 2'b11) return 1'b1;
      return cur;
    end
    if (c == 2'b01) return (m_w2 && m) ? ~cur : cur;  // R3
    if (c == 2'b10) return w ? 1'b1 : (m && !ign) ? 1'b0 : cur; // R4 R5
    if (c == 2'b11) return w ? 1'b0 : (m && !ign) ? 1'b1 : cur;
    return cur;
  endfunction

  task automatic compare_all();
    chk("R9 oc_a", oc_a, m_oa);
    chk("R9 oc_b", oc_b, m_ob);
    chk("R6 ovr_a", ovr_a, m_ovr(m_ca));
    chk("R6 ovr_b", ovr_b, m_ovr(m_cb));
    chk("R7 pad_a_en", pad_a_en, ddr_a);
    chk("R7 pad_b_en", pad_b_en, ddr_b);
    chk("R7 pad_a", pad_a, m_ovr(m_ca) ? m_oa : port_a);
    chk("R7 pad_b", pad_b, m_ovr(m_cb) ? m_ob : port_b);
    chk("R1 rd_data", rd_data, m_rd(addr));
  endtask

  task automatic step(input logic t, input logic we, input logic [2:0] a,
                      input logic [7:0] d, input logic pa, input logic da,
                      input logic pb, input logic db);
    logic w;
    @(negedge clk);
    compare_all();
    tick = t; wr_en = we; addr = a; wr_data = d;
    port_a = pa; ddr_a = da; port_b = pb; ddr_b = db;
    w = (m_cnt == m_top());
    if (t) begin
      m_oa = m_next(m_oa, m_ca, m_aa);
      m_ob = m_next(m_ob, m_cb, m_ab);
      m_cnt = w ? 8'h00 : m_cnt + 8'h01;   // R8 R11
      if (m_pwm() && w) begin m_aa = m_ba; m_ab = m_bb; end  // R10
    end
    if (we) begin
      case (a)
        3'd0: begin m_ca = d[7:6]; m_cb = d[5:4]; m_wl = d[1:0]; end
        3'd1: m_w2 = d[3];
        3'd2: begin m_ba = d; if (!m_pwm()) m_aa = d; end
        3'd3: begin m_bb = d; if (!m_pwm()) m_ab = d; end
        default: ;
      endcase
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] oa_l[3], ob_l[3];
    logic [2:0] wg_l[5];
    oa_l = '{8'h06, 8'h04, 8'hFF};
    ob_l = '{8'h03, 8'h04, 8'hFF};
    wg_l = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b111};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state of every register
    for (int a = 0; a < 5; a++) step(0, 0, 3'(a), 8'h00, 0, 0, 0, 0);
    // R1 reserved bits read zero
    step(0, 1, 3'd0, 8'hFC, 0, 0, 0, 0);
    step(0, 0, 3'd0, 8'h00, 0, 0, 0, 0);
    step(0, 1, 3'd1, 8'hFF, 0, 0, 0, 0);
    step(0, 0, 3'd1, 8'h00, 0, 0, 0, 0);
    for (int g = 0; g < 5; g++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 3; p++) begin
          step(0, 1, 3'd1, {4'b0, wg_l[g][2], 3'b0}, 0, 0, 0, 0);
          step(0, 1, 3'd0, {2'(c), 2'(3 - c), 2'b00, wg_l[g][1:0]}, 0, 0, 0, 0);
          step(0, 1, 3'd2, oa_l[p], 0, 0, 0, 0);
          step(0, 1, 3'd3, ob_l[p], 0, 0, 0, 0);
          for (int i = 0; i < 560; i++) begin
            if (i == 200)
              step(0, 1, 3'd3, ob_l[p] - 8'h01, 0, 1, 0, 1);  // R10 mid-period write
            else
              step((i % 5) != 4, 0, 3'(4 - (i % 3) * 2), 8'h00,
                   i[1], i[2], i[2], i[3]);
          end
        end
    step(0, 0, 3'd0, 8'h00, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule